// File: doc/BRIEF.md
# Remote Terminal Built-In-Test Register Bank

This block holds the host-visible test registers of a command/response bus remote terminal. The host reaches two registers through a simple synchronous port. The first is a 16-bit alternate BIT word that the host maintains. The second is a test-control register. It combines four read-only status flags with host-writable test bits, and those bits are guarded by a test-mode pin. The flags record a RAM self-test failure, a terminal-address parity error, an auto-initialization load failure, and whether the terminal flag is currently inhibited.

When the protocol engine decodes a "transmit BIT word" mode command (mode code 19), the block supplies the response data word. A configuration bit selects the source. When it is high, the word is the alternate register. When it is low, the word is an internal BIT word built from the four flags. When the command completes, the same word is presented once more for storage in the mode-code-19 data buffer. Mode codes 6 and 7 set and clear the inhibit flag. There are two resets: an asynchronous hard master reset, and a synchronous soft reset that clears only the writable test-control bits.

Top module: `rt_bit_regs`

## Requirements
- R1: A host write to address 0x15 loads the full 16-bit alternate BIT word whatever the test pin state, and a read of 0x15 returns it.
- R2: Hard reset clears the alternate word, the test-control bits, all four flags and the buffer-write output. Soft reset clears only the writable test-control bits and leaves the alternate word and the flags unchanged.
- R3: The test-control register is at address 0x17. Its writable bits (mask 0xFCFC) take host data only when the test pin is high. Bits 9, 8, 1 and 0 are read-only and ignore writes.
- R4: While the test pin is low, the writable test-control bits read as zero. Their stored value returns when the pin goes high again.
- R5: Bit 0 (terminal flag inhibited) is set the cycle after a mode-code-6 completion strobe and cleared the cycle after a mode-code-7 strobe. If both strobes arrive together, the clear wins.
- R6: The 6-bit address input (five address bits plus parity) must have odd parity. An even count of ones sets bit 8 on the next cycle, and the bit stays set until hard reset.
- R7: Bit 1 (load fail) is set only when a load-fail strobe arrives while auto-initialization is enabled and before the first load-done or load-fail strobe after hard reset. Once set, it stays set until hard reset.
- R8: A RAM self-test fail strobe sets bit 9 on the next cycle, and the bit stays set until hard reset.
- R9: The mode-code-19 response word equals the alternate word when the configuration bit is 1. Otherwise it equals the internal word, which has the four flags at bits 9, 8, 1 and 0 and zeros elsewhere.
- R10: One cycle after a mode-code-19 completion strobe, the buffer write-enable is high for one cycle. Its data is the response word as it was at the strobe.
- R11: Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous master reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| host_addr | input | ADDR_W | Host register address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| test_pin | input | 1 | Test-mode enable pin |
| cfg_alt_bitw | input | 1 | Select the alternate word for mode code 19 |
| mc6_done | input | 1 | Inhibit-terminal-flag command completed |
| mc7_done | input | 1 | Override-inhibit command completed |
| mc19_done | input | 1 | Transmit-BIT-word command completed |
| opstat_addr | input | 6 | Terminal address bits with parity bit |
| autoinit_en | input | 1 | Auto-initialization enable pin |
| eeprom_fail | input | 1 | Auto-initialization load failure strobe |
| eeprom_done | input | 1 | Auto-initialization load finished strobe |
| ramtest_fail | input | 1 | RAM self-test error strobe |
| mc19_word | output | 16 | Mode-code-19 response data word |
| mc19_buf_we | output | 1 | Mode-code-19 buffer write enable |
| mc19_buf_wdata | output | 16 | Mode-code-19 buffer write data |

## Verification
The load-fail flag is the hardest state to reach. It needs auto-initialization enabled and a fail strobe inside the short window after a hard reset, before any done strobe closes that window. The stimulus repeats hard resets directly and then sends fail strobes both inside and outside the window, with the enable pin both high and low. Random traffic also drives the test pin, simultaneous mode-code-6 and mode-code-7 strobes, and rare parity errors, so that masked readback and sticky flags are seen in combination.

// File: rtl/rt_bit_pkg.sv
package rt_bit_pkg;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] TCTL_WR_MASK = 16'hFCFC;
  localparam int POS_MEM = 9;
  localparam int POS_PAR = 8;
  localparam int POS_EEL = 1;
  localparam int POS_TFI = 0;

  typedef struct packed {
    logic mem;
    logic par;
    logic eel;
    logic tfi;
  } bit_flags_t;

  function automatic logic addr_parity_ok(input logic [5:0] v);
    return ^v;
  endfunction

  function automatic logic [DATA_W-1:0] make_bit_word(input bit_flags_t f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POS_MEM] = f.mem;
    w[POS_PAR] = f.par;
    w[POS_EEL] = f.eel;
    w[POS_TFI] = f.tfi;
    return w;
  endfunction
endpackage

// File: rtl/bit_flag_tracker.sv
module bit_flag_tracker
  import rt_bit_pkg::*;
(
  input  logic       clk,
  input  logic       hard_rst_n,
  input  logic       mc6_done,
  input  logic       mc7_done,
  input  logic       par_err,
  input  logic       ramtest_fail,
  input  logic       autoinit_en,
  input  logic       eeprom_fail,
  input  logic       eeprom_done,
  output bit_flags_t flags_o
);
  bit_flags_t flags_q;
  logic       load_win_q;
  logic       eel_fire;

  assign eel_fire = eeprom_fail && autoinit_en && load_win_q;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      flags_q    <= '0;
      load_win_q <= 1'b1;
    end else begin
      if (mc7_done)      flags_q.tfi <= 1'b0;
      else if (mc6_done) flags_q.tfi <= 1'b1;
      if (par_err)       flags_q.par <= 1'b1;
      if (ramtest_fail)  flags_q.mem <= 1'b1;
      if (eel_fire)      flags_q.eel <= 1'b1;
      if (eeprom_fail || eeprom_done) load_win_q <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/bit_host_regs.sv
module bit_host_regs
  import rt_bit_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] ALT_ADDR  = 5'h15,
  parameter logic [ADDR_W-1:0] TCTL_ADDR = 5'h17
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              test_pin,
  output logic [DATA_W-1:0] alt_o,
  output logic [DATA_W-1:0] tctl_wr_o,
  output logic              alt_wr_fire_o,
  output logic              tctl_wr_fire_o
);
  logic [DATA_W-1:0] alt_q;
  logic [DATA_W-1:0] tctl_q;

  assign alt_wr_fire_o  = we && (addr == ALT_ADDR);
  assign tctl_wr_fire_o = we && (addr == TCTL_ADDR) && test_pin;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      alt_q  <= '0;
      tctl_q <= '0;
    end else begin
      if (alt_wr_fire_o) alt_q <= wdata;
      if (soft_rst)            tctl_q <= '0;
      else if (tctl_wr_fire_o) tctl_q <= wdata & TCTL_WR_MASK;
    end
  end

  assign alt_o     = alt_q;
  assign tctl_wr_o = tctl_q;
endmodule

// File: rtl/bit_mc19_path.sv
module bit_mc19_path
  import rt_bit_pkg::*;
(
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              cfg_alt,
  input  logic [DATA_W-1:0] alt_word,
  input  bit_flags_t        flags,
  input  logic              mc19_done,
  output logic [DATA_W-1:0] word_o,
  output logic              buf_we_o,
  output logic [DATA_W-1:0] buf_wdata_o
);
  logic [DATA_W-1:0] int_word;

  assign int_word = make_bit_word(flags);
  assign word_o   = cfg_alt ? alt_word : int_word;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      buf_we_o    <= 1'b0;
      buf_wdata_o <= '0;
    end else begin
      buf_we_o <= mc19_done;
      if (mc19_done) buf_wdata_o <= word_o;
    end
  end
endmodule

// File: rtl/rt_bit_regs.sv
module rt_bit_regs
  import rt_bit_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] ALT_ADDR  = 5'h15,
  parameter logic [ADDR_W-1:0] TCTL_ADDR = 5'h17
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              test_pin,
  input  logic              cfg_alt_bitw,
  input  logic              mc6_done,
  input  logic              mc7_done,
  input  logic              mc19_done,
  input  logic [5:0]        opstat_addr,
  input  logic              autoinit_en,
  input  logic              eeprom_fail,
  input  logic              eeprom_done,
  input  logic              ramtest_fail,
  output logic [15:0]       mc19_word,
  output logic              mc19_buf_we,
  output logic [15:0]       mc19_buf_wdata
);
  bit_flags_t        flags;
  logic [3:0]        flags_vec;
  logic [DATA_W-1:0] alt_q;
  logic [DATA_W-1:0] tctl_wr;
  logic              alt_wr_fire;
  logic              tctl_wr_fire;
  logic              par_err;

  assign par_err   = !addr_parity_ok(opstat_addr);
  assign flags_vec = flags;

  bit_flag_tracker u_flags (
    .clk(clk), .hard_rst_n(hard_rst_n), .mc6_done(mc6_done), .mc7_done(mc7_done),
    .par_err(par_err), .ramtest_fail(ramtest_fail), .autoinit_en(autoinit_en),
    .eeprom_fail(eeprom_fail), .eeprom_done(eeprom_done), .flags_o(flags)
  );

  bit_host_regs #(.ADDR_W(ADDR_W), .ALT_ADDR(ALT_ADDR), .TCTL_ADDR(TCTL_ADDR)) u_regs (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .addr(host_addr),
    .we(host_we), .wdata(host_wdata), .test_pin(test_pin), .alt_o(alt_q),
    .tctl_wr_o(tctl_wr), .alt_wr_fire_o(alt_wr_fire), .tctl_wr_fire_o(tctl_wr_fire)
  );

  bit_mc19_path u_mc19 (
    .clk(clk), .hard_rst_n(hard_rst_n), .cfg_alt(cfg_alt_bitw), .alt_word(alt_q),
    .flags(flags), .mc19_done(mc19_done), .word_o(mc19_word),
    .buf_we_o(mc19_buf_we), .buf_wdata_o(mc19_buf_wdata)
  );

  always_comb begin
    if (host_addr == ALT_ADDR)
      host_rdata = alt_q;
    else if (host_addr == TCTL_ADDR)
      host_rdata = make_bit_word(flags) | (test_pin ? tctl_wr : '0);
    else
      host_rdata = '0;
  end
endmodule

// File: rtl/rt_bit_regs_chk.sv
module rt_bit_regs_chk #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] TCTL_ADDR = 5'h17
) (
  input logic              clk,
  input logic              hard_rst_n,
  input logic              soft_rst,
  input logic              alt_wr_fire,
  input logic              tctl_wr_fire,
  input logic [15:0]       host_wdata,
  input logic [15:0]       alt_q,
  input logic [3:0]        flags_vec,
  input logic              mc6_done,
  input logic              mc7_done,
  input logic              ramtest_fail,
  input logic              mc19_done,
  input logic              mc19_buf_we,
  input logic              cfg_alt_bitw,
  input logic [15:0]       mc19_word,
  input logic [15:0]       host_rdata,
  input logic [ADDR_W-1:0] host_addr,
  input logic              test_pin
);
  assert_alt_write_R1: assert property (@(posedge clk) disable iff (!hard_rst_n)
    alt_wr_fire |=> (alt_q == $past(host_wdata)));

  assert_soft_keeps_alt_R2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (soft_rst && !alt_wr_fire) |=> $stable(alt_q));

  assert_tctl_gate_R3: assert property (@(posedge clk) disable iff (!hard_rst_n)
    tctl_wr_fire |-> test_pin);

  assert_mask_low_R4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (host_addr == TCTL_ADDR && !test_pin) |-> ((host_rdata & 16'hFCFC) == 16'h0000));

  assert_inhibit_set_R5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (mc6_done && !mc7_done) |=> flags_vec[0]);

  assert_inhibit_clr_R5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    mc7_done |=> !flags_vec[0]);

  assert_mem_sticky_R8: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (ramtest_fail || flags_vec[3]) |=> flags_vec[3]);

  assert_alt_select_R9: assert property (@(posedge clk) disable iff (!hard_rst_n)
    cfg_alt_bitw |-> (mc19_word == alt_q));

  assert_buf_write_R10: assert property (@(posedge clk) disable iff (!hard_rst_n)
    mc19_done |=> mc19_buf_we);
endmodule

bind rt_bit_regs rt_bit_regs_chk #(.ADDR_W(ADDR_W), .TCTL_ADDR(TCTL_ADDR)) u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .alt_wr_fire(alt_wr_fire),
  .tctl_wr_fire(tctl_wr_fire), .host_wdata(host_wdata), .alt_q(alt_q),
  .flags_vec(flags_vec), .mc6_done(mc6_done), .mc7_done(mc7_done),
  .ramtest_fail(ramtest_fail), .mc19_done(mc19_done), .mc19_buf_we(mc19_buf_we),
  .cfg_alt_bitw(cfg_alt_bitw), .mc19_word(mc19_word), .host_rdata(host_rdata),
  .host_addr(host_addr), .test_pin(test_pin)
);

// File: tb/rt_bit_regs_tb.sv
`timescale 1ns/1ps
module rt_bit_regs_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        hard_rst_n = 1'b0, soft_rst = 1'b0;
  logic [4:0]  host_addr = 5'h0;
  logic        host_we = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        test_pin = 1'b0, cfg_alt_bitw = 1'b0;
  logic        mc6_done = 1'b0, mc7_done = 1'b0, mc19_done = 1'b0;
  logic [5:0]  opstat_addr = 6'b000001;
  logic        autoinit_en = 1'b0, eeprom_fail = 1'b0, eeprom_done = 1'b0, ramtest_fail = 1'b0;
  logic [15:0] mc19_word, mc19_buf_wdata;
  logic        mc19_buf_we;

  rt_bit_regs u_dut (.*);

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // bench model: flags as {mem, par, eel, tfi}
  logic [15:0] alt_m, tw_m, bwd_m;
  logic [3:0]  fl_m;
  logic        win_m, bwe_m;

  function automatic logic odd_ok(input logic [5:0] v);
    int n = 0;
    for (int i = 0; i < 6; i++) n += int'(v[i]);
    return (n % 2) == 1;
  endfunction

  function automatic logic [15:0] int_word();
    logic [15:0] w = 16'h0;
    w[9] = fl_m[3]; w[8] = fl_m[2]; w[1] = fl_m[1]; w[0] = fl_m[0];
    return w;
  endfunction

  function automatic logic [15:0] exp_rd();
    if (host_addr == 5'h15) return alt_m;
    if (host_addr == 5'h17) return int_word() | (test_pin ? tw_m : 16'h0);
    return 16'h0;
  endfunction

  function automatic logic [15:0] exp_word();
    return cfg_alt_bitw ? alt_m : int_word();
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bwe_m = mc19_done;
    if (mc19_done) bwd_m = exp_word();
    if (mc7_done) fl_m[0] = 1'b0; else if (mc6_done) fl_m[0] = 1'b1;
    if (!odd_ok(opstat_addr)) fl_m[2] = 1'b1;
    if (ramtest_fail) fl_m[3] = 1'b1;
    if (eeprom_fail && autoinit_en && win_m) fl_m[1] = 1'b1;
    if (eeprom_fail || eeprom_done) win_m = 1'b0;
    if (host_we && host_addr == 5'h15) alt_m = host_wdata;
    if (soft_rst) tw_m = 16'h0;
    else if (host_we && host_addr == 5'h17 && test_pin) tw_m = host_wdata & 16'hFCFC;
  endtask

  // inputs already set after a negedge: check combinational/registered outputs, then clock
  task automatic step(input string req);
    #1;
    chk({req, " rdata"}, host_rdata, exp_rd());
    chk({req, " R9 word"}, mc19_word, exp_word());
    chk({req, " R10 we"}, {15'h0, mc19_buf_we}, {15'h0, bwe_m});
    chk({req, " R10 data"}, mc19_buf_wdata, bwd_m);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    host_we = 1'b0; soft_rst = 1'b0; mc6_done = 1'b0; mc7_done = 1'b0; mc19_done = 1'b0;
    eeprom_fail = 1'b0; eeprom_done = 1'b0; ramtest_fail = 1'b0; opstat_addr = 6'b000001;
  endtask

  task automatic do_hard_reset();
    idle();
    hard_rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    hard_rst_n = 1'b1;
    alt_m = 16'h0; tw_m = 16'h0; bwd_m = 16'h0; fl_m = 4'h0; win_m = 1'b1; bwe_m = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input string req);
    host_addr = a; host_we = 1'b1; host_wdata = d;
    step(req);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string req);
    host_addr = a;
    step(req);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_hard_reset();
    // R2 reset state
    test_pin = 1'b1;
    rd(5'h15, "R2 reset alt");
    rd(5'h17, "R2 reset tctl");
    // R1 alt write with test pin low
    test_pin = 1'b0;
    wr(5'h15, 16'hA5C3, "R1 write");
    rd(5'h15, "R1 read");
    // R3 gated write, read-only bits ignored
    wr(5'h17, 16'hFFFF, "R3 gated low");
    test_pin = 1'b1;
    rd(5'h17, "R3 no write while low");
    wr(5'h17, 16'hFFFF, "R3 write high");
    rd(5'h17, "R3 ro bits ignored");
    // R4 masking retains contents
    test_pin = 1'b0;
    rd(5'h17, "R4 masked");
    test_pin = 1'b1;
    rd(5'h17, "R4 restored");
    // R11 other address
    rd(5'h16, "R11 other");
    // R2 soft reset
    soft_rst = 1'b1; host_addr = 5'h17; step("R2 soft");
    soft_rst = 1'b0;
    rd(5'h17, "R2 soft cleared tctl");
    rd(5'h15, "R2 soft kept alt");
    // R5 inhibit
    mc6_done = 1'b1; host_addr = 5'h17; step("R5 mc6");
    mc6_done = 1'b0; rd(5'h17, "R5 set");
    mc6_done = 1'b1; mc7_done = 1'b1; step("R5 both");
    mc6_done = 1'b0; mc7_done = 1'b0; rd(5'h17, "R5 clear wins");
    // R9/R10 both sources
    cfg_alt_bitw = 1'b0; mc19_done = 1'b1; step("R9 internal");
    mc19_done = 1'b0; cfg_alt_bitw = 1'b1; mc19_done = 1'b1; step("R10 capture");
    mc19_done = 1'b0; step("R10 pulse");
    step("R10 end");
    // R6 parity, R8 ram test
    opstat_addr = 6'b000011; step("R6 bad parity");
    opstat_addr = 6'b000111; rd(5'h17, "R6 sticky");
    ramtest_fail = 1'b1; step("R8 fail");
    ramtest_fail = 1'b0; rd(5'h17, "R8 sticky");
    // R7 load fail window
    do_hard_reset();
    autoinit_en = 1'b0; eeprom_fail = 1'b1; host_addr = 5'h17; step("R7 disabled");
    eeprom_fail = 1'b0; rd(5'h17, "R7 not set disabled");
    do_hard_reset();
    autoinit_en = 1'b1; eeprom_done = 1'b1; host_addr = 5'h17; step("R7 done");
    eeprom_done = 1'b0; eeprom_fail = 1'b1; step("R7 late fail");
    eeprom_fail = 1'b0; rd(5'h17, "R7 window closed");
    do_hard_reset();
    eeprom_fail = 1'b1; host_addr = 5'h17; step("R7 early fail");
    eeprom_fail = 1'b0; rd(5'h17, "R7 set");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 299) == 0) begin
        autoinit_en = $urandom_range(0, 1) == 1;
        do_hard_reset();
      end
      case ($urandom_range(0, 3))
        0: host_addr = 5'h15;
        1, 2: host_addr = 5'h17;
        default: host_addr = 5'($urandom);
      endcase
      host_we      = $urandom_range(0, 2) == 0;
      host_wdata   = 16'($urandom);
      test_pin     = $urandom_range(0, 1) == 1;
      cfg_alt_bitw = $urandom_range(0, 1) == 1;
      soft_rst     = $urandom_range(0, 40) == 0;
      mc6_done     = $urandom_range(0, 6) == 0;
      mc7_done     = $urandom_range(0, 6) == 0;
      mc19_done    = $urandom_range(0, 4) == 0;
      ramtest_fail = $urandom_range(0, 500) == 0;
      eeprom_fail  = $urandom_range(0, 20) == 0;
      eeprom_done  = $urandom_range(0, 20) == 0;
      opstat_addr  = 6'($urandom);
      if ($urandom_range(0, 99) != 0) opstat_addr[5] = ~(^opstat_addr[4:0]);
      step("R1 R3 R4 R6 random");
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule